// File: doc/BRIEF.md
# Extended Control Register Bank with Test FIFO

This block is the register bank of a parallel port's extended control window. A byte-wide host interface with a 3-bit offset reaches four locations. One is a control byte that holds a 3-bit operating mode and reports the state of a small byte FIFO. One is a second configuration byte. One is a data location whose meaning depends on the mode. The remaining offsets are unused.

In the FIFO-test mode, the data location at offset 0 becomes the FIFO port. A write pushes a byte and a read pops one. In every other mode, offset 0 is a plain holding byte. Any write to the control byte that changes the mode empties the FIFO. Software uses this to put the FIFO into a known state before a test.

Top module: `xctl_regbank`

## Requirements
- R1: After reset, the control byte (offset 2) reads 0x01: compatibility mode (000) in bits 7:5, bits 4:2 at zero, and the empty code 01 in bits 1:0. Offsets 0 and 1 read 0x00.
- R2: A write to offset 2 replaces the mode in bits 7:5 with the written bits 7:5. The written bits 4:0 have no effect: bits 4:2 always read 0 and bits 1:0 always show FIFO status.
- R3: Offset 1 is a configuration byte that reads back the last value written to it.
- R4: When the mode is not FIFO-test (110), offset 0 is a holding byte that reads back its last written value. Reading it changes nothing.
- R5: In FIFO-test mode, a write to offset 0 pushes the byte into a FIFO of DEPTH bytes. The status in bits 1:0 then reads 10 when DEPTH bytes are held and 00 when between 1 and DEPTH-1 are held.
- R6: In FIFO-test mode, a read of offset 0 returns the oldest held byte and removes it. The order is first in, first out, and it holds across pointer wrap. The status reads 01 once no bytes remain.
- R7: A push while the FIFO holds DEPTH bytes is dropped. Neither the contents nor the status change.
- R8: A read of offset 0 in FIFO-test mode with the FIFO empty returns the most recently popped byte (0x00 if none since reset) and removes nothing.
- R9: A control write whose mode differs from the current mode empties the FIFO, so the status reads 01. A control write with the same mode leaves the FIFO untouched.
- R10: Writes to offsets 3 to 7 have no effect on any location, and those offsets read 0x00.
- R11: In FIFO-test mode, writes to offset 0 leave the holding byte unchanged. It is still visible after leaving FIFO-test mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one byte per cycle |
| rd_en | input | 1 | Host read strobe; side effects only when wr_en is low |
| addr | input | AW | Register offset |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for the current offset, combinational |

## Verification
The bench builds the block with DEPTH = 2 and DW = 8. These are the values at which the status encoding is defined. At a depth of two, every second push wraps the write pointer and the full code appears after only two pushes. Dropped pushes, empty pops, flushes from a mode change and repeated wrap rounds can therefore all be reached within a few dozen host accesses. These cases are checked against a queue model on every access.

// File: rtl/xctl_pkg.sv
package xctl_pkg;

  typedef enum logic [2:0] {
    MD_COMPAT  = 3'b000,
    MD_BYTE    = 3'b001,
    MD_PPFIFO  = 3'b010,
    MD_ECPFIFO = 3'b011,
    MD_EPP     = 3'b100,
    MD_RSVD    = 3'b101,
    MD_FTEST   = 3'b110,
    MD_CONFIG  = 3'b111
  } xmode_e;

  localparam logic [1:0] ST_SOME  = 2'b00;
  localparam logic [1:0] ST_EMPTY = 2'b01;
  localparam logic [1:0] ST_FULL  = 2'b10;

  localparam int OFS_DATA = 0;
  localparam int OFS_CFGB = 1;
  localparam int OFS_CTL  = 2;

  function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  function automatic logic [1:0] fifo_status(int unsigned cnt, int unsigned depth);
    if (cnt == 0)          return ST_EMPTY;
    else if (cnt >= depth) return ST_FULL;
    else                   return ST_SOME;
  endfunction

endpackage

// File: rtl/xctl_hreg.sv
module xctl_hreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/xctl_mode_reg.sv
module xctl_mode_reg
  import xctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [2:0] wmode,
  output xmode_e     mode,
  output logic       chg
);
  assign chg = we && (wmode != mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mode <= MD_COMPAT;
    else if (we) mode <= xmode_e'(wmode);
  end
endmodule

// File: rtl/xctl_fifo.sv
module xctl_fifo
  import xctl_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 2,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] rd_byte,
  output logic [CW-1:0] cnt
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] last_q;
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic          full, empty, push_ok, pop_ok;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rd_byte = empty ? last_q : mem_q[rd_ptr_q];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[g] <= '0;
      else if (push_ok && !flush && (wr_ptr_q == PW'(g))) mem_q[g] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt      <= '0;
      last_q   <= '0;
    end else if (flush) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt      <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= PW'(wrap_inc(int'(wr_ptr_q), DEPTH));
      if (pop_ok) begin
        rd_ptr_q <= PW'(wrap_inc(int'(rd_ptr_q), DEPTH));
        last_q   <= mem_q[rd_ptr_q];
      end
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/xctl_regbank.sv
module xctl_regbank
  import xctl_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 2,
  parameter int AW    = 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  xmode_e        mode;
  logic          is_ftest, rd_act;
  logic          push_req, pop_req, hold_we, cfg_we, ecr_we, mode_chg;
  logic [DW-1:0] hold_q, cfgb_q, fifo_rd;
  logic [CW-1:0] fifo_cnt;
  logic [1:0]    status;

  assign is_ftest = (mode == MD_FTEST);
  assign rd_act   = rd_en && !wr_en;
  assign push_req = wr_en  && (addr == AW'(OFS_DATA)) && is_ftest;
  assign pop_req  = rd_act && (addr == AW'(OFS_DATA)) && is_ftest;
  assign hold_we  = wr_en  && (addr == AW'(OFS_DATA)) && !is_ftest;
  assign cfg_we   = wr_en  && (addr == AW'(OFS_CFGB));
  assign ecr_we   = wr_en  && (addr == AW'(OFS_CTL));
  assign status   = fifo_status(int'(fifo_cnt), DEPTH);

  xctl_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .we(ecr_we), .wmode(wdata[DW-1:DW-3]),
    .mode(mode), .chg(mode_chg)
  );

  xctl_hreg #(.W(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .we(hold_we), .d(wdata), .q(hold_q)
  );

  xctl_hreg #(.W(DW)) u_cfgb (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .d(wdata), .q(cfgb_q)
  );

  xctl_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(mode_chg), .push(push_req), .pop(pop_req),
    .din(wdata), .rd_byte(fifo_rd), .cnt(fifo_cnt)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(OFS_DATA): rdata = is_ftest ? fifo_rd : hold_q;
      AW'(OFS_CFGB): rdata = cfgb_q;
      AW'(OFS_CTL):  rdata = {mode, {(DW-5){1'b0}}, status};
      default:       rdata = '0;
    endcase
  end
endmodule

// File: rtl/xctl_regbank_chk.sv
module xctl_regbank_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 2,
  parameter int AW    = 3,
  parameter int CW    = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          push_req,
  input logic          pop_req,
  input logic          mode_chg,
  input logic [CW-1:0] fifo_cnt
);
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

  p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && fifo_cnt == CW'(DEPTH) && !mode_chg) |=> fifo_cnt == CW'(DEPTH));

  p_push_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && fifo_cnt < CW'(DEPTH)) |=> fifo_cnt == $past(fifo_cnt) + CW'(1));

  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && fifo_cnt == '0) |=> fifo_cnt == '0);

  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> fifo_cnt == '0);

  p_empty_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(2) && fifo_cnt == '0) |-> rdata[1:0] == 2'b01);

  p_ctl_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(2)) |-> rdata[DW-4:2] == '0);

  p_mode_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(2)) ##1 (addr == AW'(2)) |-> rdata[DW-1:DW-3] == $past(wdata[DW-1:DW-3]));

  p_unused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > AW'(2)) |-> rdata == '0);
endmodule

bind xctl_regbank xctl_regbank_chk #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
  .push_req(push_req), .pop_req(pop_req), .mode_chg(mode_chg), .fifo_cnt(fifo_cnt)
);

// File: tb/xctl_regbank_tb.sv
module xctl_regbank_tb_top;
  localparam int DW    = 8;
  localparam int DEPTH = 2;
  localparam int AW    = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [2:0]    m_mode = 3'b000;
  logic [DW-1:0] m_hold = '0, m_cfg = '0, m_last = '0;
  logic [DW-1:0] m_q[$];

  xctl_regbank #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] exp_rd(logic [AW-1:0] a);
    logic [1:0] st;
    st = (m_q.size() == 0) ? 2'b01 : (m_q.size() == DEPTH) ? 2'b10 : 2'b00;
    case (a)
      3'd0:    return (m_mode == 3'b110) ? ((m_q.size() > 0) ? m_q[0] : m_last) : m_hold;
      3'd1:    return m_cfg;
      3'd2:    return {m_mode, 3'b000, st};
      default: return '0;
    endcase
  endfunction

  task automatic check(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic op(input bit is_wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input string tag);
    @(negedge clk);
    addr = a; wdata = d; wr_en = is_wr; rd_en = !is_wr;
    #1;
    check(rdata, exp_rd(a), tag);
    @(posedge clk);
    #1;
    if (is_wr) begin
      case (a)
        3'd0: if (m_mode == 3'b110) begin
                if (m_q.size() < DEPTH) m_q.push_back(d);
              end else m_hold = d;
        3'd1: m_cfg = d;
        3'd2: begin
                if (d[7:5] != m_mode) m_q.delete();
                m_mode = d[7:5];
              end
        default: ;
      endcase
    end else if (a == 3'd0 && m_mode == 3'b110 && m_q.size() > 0) begin
      m_last = m_q.pop_front();
    end
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    op(1'b1, a, d, tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    op(1'b0, a, '0, tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset values
    rd(3'd2, "R1"); rd(3'd1, "R1"); rd(3'd0, "R1");
    // R2 mode replacement and read-only low bits
    wr(3'd2, 8'hFF, "R2"); rd(3'd2, "R2");
    wr(3'd2, 8'h1E, "R2"); rd(3'd2, "R2");
    // R4 holding byte
    wr(3'd0, 8'hA5, "R4"); rd(3'd0, "R4"); rd(3'd0, "R4");
    // R3 configuration byte
    wr(3'd1, 8'h3C, "R3"); rd(3'd1, "R3");
    // R10 unused offsets
    for (int a = 3; a < 8; a++) begin
      wr(3'(a), 8'hFF, "R10"); rd(3'(a), "R10");
    end
    rd(3'd0, "R10"); rd(3'd1, "R10"); rd(3'd2, "R10");
    // R5 push into FIFO-test mode
    wr(3'd2, 8'hC0, "R9"); rd(3'd2, "R5");
    wr(3'd0, 8'h11, "R5"); rd(3'd2, "R5");
    wr(3'd0, 8'h22, "R5"); rd(3'd2, "R5");
    // R7 dropped push
    wr(3'd0, 8'h33, "R7"); rd(3'd2, "R7");
    // R6 pop order and status
    rd(3'd0, "R6"); rd(3'd2, "R6"); rd(3'd0, "R6"); rd(3'd2, "R6");
    // R8 pop on empty
    rd(3'd0, "R8"); rd(3'd0, "R8"); rd(3'd2, "R8");
    // R9 same-mode write keeps data, mode change flushes
    wr(3'd0, 8'h44, "R9"); wr(3'd2, 8'hC3, "R9"); rd(3'd2, "R9");
    wr(3'd2, 8'h20, "R9"); rd(3'd2, "R9");
    wr(3'd2, 8'hC0, "R9"); rd(3'd2, "R9"); rd(3'd0, "R8");
    // R6 wrap rounds
    for (int i = 0; i < 5; i++) begin
      wr(3'd0, 8'(8'h50 + 2*i), "R6");
      wr(3'd0, 8'(8'h51 + 2*i), "R6");
      rd(3'd0, "R6");
      wr(3'd0, 8'(8'h80 + i), "R6");
      rd(3'd0, "R6"); rd(3'd0, "R6"); rd(3'd2, "R6");
    end
    // R11 holding byte untouched by FIFO-test writes
    wr(3'd2, 8'h00, "R11"); rd(3'd0, "R11");
    rd(3'd2, "R1");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule